// File: doc/BRIEF.md
# DDR Command Spacing Monitor

This block watches the command bus of a four-bank, two-bit-prefetch DDR memory without driving anything on it. Each clock it turns the chip select, row strobe, column strobe and write enable levels into a command. It keeps an open or idle flag for every bank. It also keeps saturating cycle counters that measure how long ago each relevant earlier command was issued.

When a command comes too soon after an earlier one, or goes to a bank in the wrong state, the block raises a single-cycle violation pulse one clock later. A 4-bit code with the pulse names the broken rule. Burst length and CAS latency are plain configuration inputs, and the minimum spacings scale with them. A controller team places the monitor on a simulated or emulated command bus to catch sequencing errors.

Top module: `ddr_cmd_checker`

## Requirements
- R1: After reset, `viol` and `viol_code` are 0, every bank is idle, and every counter reads as "long ago", so the first command can break no spacing rule.
- R2: When `cs_n`=1 is sampled, the command is ignored. It changes no bank state and no counter, and it raises no violation. With `cs_n`=0 the pins {ras_n,cas_n,we_n} decode as: 011 activate, 101 read, 100 write, 010 precharge, 000 mode set, 110 burst stop, 001 refresh, 111 no-op. Bank index = 2*BA0 + BA1, where `bank_addr[1]` is BA1 and `bank_addr[0]` is BA0.
- R3: An activate to an open bank gives code 2. A read or write to an idle bank gives code 3.
- R4: A precharge with `a10`=1 closes all banks, and with `a10`=0 closes only the addressed bank. A read or write with `a10`=1 closes its bank after the access.
- R5: An activate or mode set fewer than 2 cycles after a mode set gives code 1.
- R6: With H = BL/2 (`bl_sel` 0→BL2, 1→BL4, 2 or 3→BL8), a precharge that targets a bank written fewer than 3+H cycles earlier gives code 4. A precharge that targets a bank read fewer than H cycles earlier gives code 5.
- R7: A read fewer than 2+H cycles after any write gives code 6.
- R8: A write fewer than 2+H+C cycles after any read gives code 7, where C = `cl_half` (1 selects CAS latency 2.5, 0 selects 2).
- R9: A write fewer than 2+C cycles after a burst stop gives code 8.
- R10: The violation shows one cycle after the offending command as a one-cycle `viol` pulse. When several rules break at once, the lowest code is reported. `viol_code` is 0 whenever `viol` is 0.
- R11: Counters saturate, so a gap of any length, including 40 cycles or more, never reads as a short gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_addr | input | 2 | Bank address; bit 1 is BA1, bit 0 is BA0 |
| a10 | input | 1 | All-bank precharge / auto-precharge select |
| bl_sel | input | 2 | Burst length select: 0=2, 1=4, 2 or 3=8 |
| cl_half | input | 1 | 1 for CAS latency 2.5, 0 for 2 |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 4 | Rule broken (1..8), 0 when quiet |

## Verification
A state rule and a spacing rule can both trip on the same command. For example, a write to a bank that is already idle can arrive one cycle after a read. The idle-bank rule (code 3) and the read-to-write rule (code 7) then both fire. The bench forces this case with a read that auto-precharges its bank, followed at once by a write to that bank, and it expects code 3. Random traffic with short gaps also produces many mixed cases. The bench's reference model computes every broken rule independently and expects the lowest code.

// File: rtl/ddrchk_pkg.sv
package ddrchk_pkg;
   localparam int CODE_W = 4;
   localparam int NRULE  = 8;

   typedef enum logic [2:0] {
      C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_MRS, C_BST, C_REF
   } cmd_e;

   // code values; a lower value wins when several rules fire together
   localparam logic [CODE_W-1:0] V_NONE     = 4'd0;
   localparam logic [CODE_W-1:0] V_MRS_GAP  = 4'd1;
   localparam logic [CODE_W-1:0] V_ACT_OPEN = 4'd2;
   localparam logic [CODE_W-1:0] V_RW_IDLE  = 4'd3;
   localparam logic [CODE_W-1:0] V_WR_PRE   = 4'd4;
   localparam logic [CODE_W-1:0] V_RD_PRE   = 4'd5;
   localparam logic [CODE_W-1:0] V_WR_RD    = 4'd6;
   localparam logic [CODE_W-1:0] V_RD_WR    = 4'd7;
   localparam logic [CODE_W-1:0] V_BST_WR   = 4'd8;

   function automatic cmd_e pins_to_cmd(input logic ras_n, input logic cas_n, input logic we_n);
      case ({ras_n, cas_n, we_n})
         3'b011:  return C_ACT;
         3'b101:  return C_RD;
         3'b100:  return C_WR;
         3'b010:  return C_PRE;
         3'b000:  return C_MRS;
         3'b110:  return C_BST;
         3'b001:  return C_REF;
         default: return C_NOP;
      endcase
   endfunction
endpackage

// File: rtl/ddrchk_decode.sv
module ddrchk_decode
   import ddrchk_pkg::*;
#(
   parameter int NBANK = 4,
   localparam int BA_W = $clog2(NBANK)
) (
   input  logic             cs_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic [BA_W-1:0]  bank_addr,
   input  logic             a10,
   output cmd_e             cmd,
   output logic [NBANK-1:0] hit,
   output logic             all_banks,
   output logic             auto_pre
);
   if (NBANK < 2 || NBANK != (1 << BA_W)) begin : g_bad_nbank
      $error("NBANK must be a power of two, at least 2");
   end

   // bank numbering takes the address bits in reversed order
   logic [BA_W-1:0] idx;
   for (genvar i = 0; i < BA_W; i++) begin : g_rev
      assign idx[i] = bank_addr[BA_W-1-i];
   end

   always_comb begin
      cmd       = cs_n ? C_NOP : pins_to_cmd(ras_n, cas_n, we_n);
      hit       = '0;
      hit[idx]  = 1'b1;
      all_banks = (cmd == C_PRE) && a10;
      auto_pre  = ((cmd == C_RD) || (cmd == C_WR)) && a10;
   end
endmodule

// File: rtl/ddrchk_gap_ctr.sv
module ddrchk_gap_ctr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = '1;

   if (W < 2) begin : g_bad_w
      $error("gap counter needs at least 2 bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= TOP;
      else if (restart)       cnt <= W'(1);
      else if (cnt != TOP)    cnt <= cnt + W'(1);
   end

   a_r11_holds_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && cnt == TOP) |=> cnt == TOP);
   a_r11_restart_one: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> cnt == W'(1));
endmodule

// File: rtl/ddrchk_banks.sv
module ddrchk_banks
   import ddrchk_pkg::*;
#(
   parameter int NBANK = 4,
   parameter int W     = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  cmd_e                      cmd,
   input  logic [NBANK-1:0]          hit,
   input  logic                      all_banks,
   input  logic                      auto_pre,
   output logic [NBANK-1:0]          open_q,
   output logic [NBANK-1:0][W-1:0]   wr_cnt,
   output logic [NBANK-1:0][W-1:0]   rd_cnt
);
   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic open_r;
      logic close_now;

      assign close_now = ((cmd == C_PRE) && (all_banks || hit[b])) ||
                         (auto_pre && hit[b]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          open_r <= 1'b0;
         else if (close_now)                  open_r <= 1'b0;
         else if ((cmd == C_ACT) && hit[b])   open_r <= 1'b1;
      end
      assign open_q[b] = open_r;

      ddrchk_gap_ctr #(.W(W)) u_wr (
         .clk(clk), .rst_n(rst_n),
         .restart((cmd == C_WR) && hit[b]), .cnt(wr_cnt[b]));
      ddrchk_gap_ctr #(.W(W)) u_rd (
         .clk(clk), .rst_n(rst_n),
         .restart((cmd == C_RD) && hit[b]), .cnt(rd_cnt[b]));

      a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
         ((cmd == C_ACT) && hit[b]) |=> open_r);
      a_r4_all_close: assert property (@(posedge clk) disable iff (!rst_n)
         all_banks |=> !open_r);
      a_r4_ap_close: assert property (@(posedge clk) disable iff (!rst_n)
         (auto_pre && hit[b]) |=> !open_r);
   end
endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker
   import ddrchk_pkg::*;
#(
   parameter int NBANK = 4,
   parameter int CNT_W = 4,
   localparam int BA_W = $clog2(NBANK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BA_W-1:0]   bank_addr,
   input  logic              a10,
   input  logic [1:0]        bl_sel,
   input  logic              cl_half,
   output logic              viol,
   output logic [CODE_W-1:0] viol_code
);
   localparam int WORST_GAP = 3 + 4 + 1;
   localparam int NGLOB     = 4;

   if ((1 << CNT_W) - 1 < WORST_GAP) begin : g_bad_cnt
      $error("CNT_W too narrow for the longest spacing rule");
   end

   cmd_e             cmd;
   logic [NBANK-1:0] hit, open_q;
   logic             all_banks, auto_pre;
   logic [NBANK-1:0][CNT_W-1:0] wr_cnt, rd_cnt;

   ddrchk_decode #(.NBANK(NBANK)) u_dec (
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .bank_addr(bank_addr), .a10(a10), .cmd(cmd), .hit(hit),
      .all_banks(all_banks), .auto_pre(auto_pre));

   ddrchk_banks #(.NBANK(NBANK), .W(CNT_W)) u_banks (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .hit(hit),
      .all_banks(all_banks), .auto_pre(auto_pre),
      .open_q(open_q), .wr_cnt(wr_cnt), .rd_cnt(rd_cnt));

   // bank-independent gaps: 0 last write, 1 last read, 2 burst stop, 3 mode set
   logic [NGLOB-1:0]            g_ev;
   logic [NGLOB-1:0][CNT_W-1:0] g_cnt;
   assign g_ev = {cmd == C_MRS, cmd == C_BST, cmd == C_RD, cmd == C_WR};
   for (genvar g = 0; g < NGLOB; g++) begin : g_glob
      ddrchk_gap_ctr #(.W(CNT_W)) u_gap (
         .clk(clk), .rst_n(rst_n), .restart(g_ev[g]), .cnt(g_cnt[g]));
   end

   // minimum spacings derived from the configuration
   logic [CNT_W-1:0] half, clx;
   logic [CNT_W-1:0] t_wr_pre, t_rd_pre, t_wr_rd, t_rd_wr, t_bst_wr, t_mrs;
   always_comb begin
      case (bl_sel)
         2'd0:    half = CNT_W'(1);
         2'd1:    half = CNT_W'(2);
         default: half = CNT_W'(4);
      endcase
      clx      = CNT_W'(cl_half);
      t_wr_pre = CNT_W'(3) + half;
      t_rd_pre = half;
      t_wr_rd  = CNT_W'(2) + half;
      t_rd_wr  = CNT_W'(2) + half + clx;
      t_bst_wr = CNT_W'(2) + clx;
      t_mrs    = CNT_W'(2);
   end

   logic             is_rw, sel_open, pre_wr_bad, pre_rd_bad;
   logic [NBANK-1:0] pre_mask;
   logic [NRULE:1]   flag;
   logic [CODE_W-1:0] code_n;

   always_comb begin
      is_rw      = (cmd == C_RD) || (cmd == C_WR);
      sel_open   = |(open_q & hit);
      pre_mask   = all_banks ? '1 : hit;
      pre_wr_bad = 1'b0;
      pre_rd_bad = 1'b0;
      for (int b = 0; b < NBANK; b++) begin
         if (pre_mask[b] && wr_cnt[b] < t_wr_pre) pre_wr_bad = 1'b1;
         if (pre_mask[b] && rd_cnt[b] < t_rd_pre) pre_rd_bad = 1'b1;
      end
      flag[1] = ((cmd == C_ACT) || (cmd == C_MRS)) && (g_cnt[3] < t_mrs);
      flag[2] = (cmd == C_ACT) && sel_open;
      flag[3] = is_rw && !sel_open;
      flag[4] = (cmd == C_PRE) && pre_wr_bad;
      flag[5] = (cmd == C_PRE) && pre_rd_bad;
      flag[6] = (cmd == C_RD) && (g_cnt[0] < t_wr_rd);
      flag[7] = (cmd == C_WR) && (g_cnt[1] < t_rd_wr);
      flag[8] = (cmd == C_WR) && (g_cnt[2] < t_bst_wr);
      code_n  = V_NONE;
      for (int c = NRULE; c >= 1; c--) begin
         if (flag[c]) code_n = CODE_W'(c);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol      <= 1'b0;
         viol_code <= V_NONE;
      end else begin
         viol      <= |flag;
         viol_code <= code_n;
      end
   end

   a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !viol);
   a_r10_quiet_code: assert property (@(posedge clk) disable iff (!rst_n)
      !viol |-> viol_code == V_NONE);
   a_r10_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      viol |-> (viol_code != V_NONE && viol_code <= CODE_W'(NRULE)));
   a_r3_idle_access: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rw && !sel_open) |=> (viol && viol_code <= V_RW_IDLE));
endmodule

// File: tb/sim_ddr_cmd_checker.sv
module sim_ddr_cmd_checker;
   localparam int K_NOP = 0, K_ACT = 1, K_RD = 2, K_WR = 3,
                  K_PRE = 4, K_MRS = 5, K_BST = 6, K_REF = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0] bank_addr = 2'd0;
   logic a10 = 1'b0;
   logic [1:0] bl_sel = 2'd1;
   logic cl_half = 1'b0;
   logic viol;
   logic [3:0] viol_code;

   always #4 clk = ~clk;

   ddr_cmd_checker u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .bank_addr(bank_addr), .a10(a10), .bl_sel(bl_sel),
      .cl_half(cl_half), .viol(viol), .viol_code(viol_code));

   int checks = 0, bad = 0;
   bit done = 1'b0;

   // reference model
   bit mopen[4];
   int dwr[4], drd[4];
   int gwr = 1000, grd = 1000, gbst = 1000, gmrs = 1000;
   int cur_bl = 1, cur_cl = 0;
   int pend_code = 0;
   string pend_tag = "R1";

   function automatic string req_of(int code);
      case (code)
         1: return "R5";
         2, 3: return "R3";
         4, 5: return "R6";
         6: return "R7";
         7: return "R8";
         8: return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic int exp_code(int c, int bk, bit a, bit cs);
      int h;
      bit f[9];
      h = (cur_bl == 0) ? 1 : (cur_bl == 1) ? 2 : 4;
      for (int i = 0; i < 9; i++) f[i] = 1'b0;
      if (cs) return 0;
      f[1] = (c == K_ACT || c == K_MRS) && gmrs < 2;
      f[2] = (c == K_ACT) && mopen[bk];
      f[3] = (c == K_RD || c == K_WR) && !mopen[bk];
      if (c == K_PRE) begin
         for (int b = 0; b < 4; b++) begin
            if (a || b == bk) begin
               if (dwr[b] < 3 + h) f[4] = 1'b1;
               if (drd[b] < h) f[5] = 1'b1;
            end
         end
      end
      f[6] = (c == K_RD) && gwr < 2 + h;
      f[7] = (c == K_WR) && grd < 2 + h + cur_cl;
      f[8] = (c == K_WR) && gbst < 2 + cur_cl;
      for (int i = 1; i < 9; i++) if (f[i]) return i;
      return 0;
   endfunction

   function automatic int bump(int v);
      return (v > 1000) ? v : v + 1;
   endfunction

   task automatic model_update(int c, int bk, bit a, bit cs);
      for (int b = 0; b < 4; b++) begin
         dwr[b] = bump(dwr[b]);
         drd[b] = bump(drd[b]);
      end
      gwr = bump(gwr); grd = bump(grd); gbst = bump(gbst); gmrs = bump(gmrs);
      if (cs) return;
      case (c)
         K_ACT: mopen[bk] = 1'b1;
         K_RD: begin drd[bk] = 1; grd = 1; if (a) mopen[bk] = 1'b0; end
         K_WR: begin dwr[bk] = 1; gwr = 1; if (a) mopen[bk] = 1'b0; end
         K_PRE: begin
            if (a) for (int b = 0; b < 4; b++) mopen[b] = 1'b0;
            else mopen[bk] = 1'b0;
         end
         K_MRS: gmrs = 1;
         K_BST: gbst = 1;
         default: ;
      endcase
   endtask

   task automatic check(string tag, int exp);
      checks++;
      if (viol !== (exp != 0) || viol_code !== 4'(exp)) begin
         bad++;
         $display("FAIL %s: actual viol=%0b code=%0d expected viol=%0b code=%0d",
                  tag, viol, viol_code, exp != 0, exp);
      end
   endtask

   // bank index k = 2*BA0 + BA1, so BA0 = k[1], BA1 = k[0]
   task automatic step(int c, int bk, bit a, bit cs, string tag);
      logic [2:0] p;
      @(negedge clk);
      check(pend_tag, pend_code);
      case (c)
         K_ACT: p = 3'b011;
         K_RD:  p = 3'b101;
         K_WR:  p = 3'b100;
         K_PRE: p = 3'b010;
         K_MRS: p = 3'b000;
         K_BST: p = 3'b110;
         K_REF: p = 3'b001;
         default: p = 3'b111;
      endcase
      {ras_n, cas_n, we_n} = p;
      cs_n      = cs;
      bank_addr = {bk[0], bk[1]};
      a10       = a;
      bl_sel    = 2'(cur_bl);
      cl_half   = cur_cl[0];
      pend_code = exp_code(c, bk, a, cs);
      pend_tag  = (tag == "") ? req_of(pend_code) : tag;
      model_update(c, bk, a, cs);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(K_NOP, 0, 1'b0, 1'b0, "");
   endtask

   initial begin
      for (int b = 0; b < 4; b++) begin
         mopen[b] = 1'b0; dwr[b] = 1000; drd[b] = 1000;
      end
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // first step checks the R1 reset state
      step(K_NOP, 0, 0, 0, "R1");
      // R2: deselected activate is ignored, so the read hits an idle bank
      step(K_ACT, 1, 0, 1, "R2");
      step(K_RD, 1, 0, 0, "R2");
      idle(6);
      // R5: activate right after mode set
      step(K_MRS, 0, 0, 0, "R5");
      step(K_ACT, 0, 0, 0, "R5");
      idle(2);
      // R3: activate of an already open bank
      step(K_ACT, 0, 0, 0, "R3");
      idle(8);
      // R6: write then precharge, read then precharge
      step(K_WR, 0, 0, 0, "R6");
      step(K_PRE, 0, 0, 0, "R6");
      idle(6);
      step(K_ACT, 0, 0, 0, "R6");
      idle(8);
      step(K_RD, 0, 0, 0, "R6");
      step(K_PRE, 0, 0, 0, "R6");
      idle(8);
      // R4: precharge-all, single precharge, auto-precharge
      step(K_ACT, 0, 0, 0, "R4");
      step(K_ACT, 1, 0, 0, "R4");
      idle(8);
      step(K_PRE, 2, 1, 0, "R4");
      idle(8);
      step(K_RD, 1, 0, 0, "R4");
      idle(8);
      step(K_ACT, 2, 0, 0, "R4");
      step(K_ACT, 3, 0, 0, "R4");
      idle(3);
      step(K_PRE, 2, 0, 0, "R4");
      idle(1);
      step(K_RD, 3, 0, 0, "R4");
      idle(8);
      step(K_RD, 2, 0, 0, "R4");
      idle(8);
      step(K_RD, 3, 1, 0, "R4");
      idle(8);
      step(K_RD, 3, 0, 0, "R4");
      idle(8);
      // R7: read two cycles after a write, BL4
      step(K_ACT, 0, 0, 0, "R7");
      idle(8);
      step(K_WR, 0, 0, 0, "R7");
      idle(1);
      step(K_RD, 0, 0, 0, "R7");
      idle(8);
      // R8: CL 2.5 boundary, gap 4 against 5 then gap 5
      cur_cl = 1;
      step(K_RD, 0, 0, 0, "R8");
      idle(3);
      step(K_WR, 0, 0, 0, "R8");
      idle(8);
      step(K_RD, 0, 0, 0, "R8");
      idle(4);
      step(K_WR, 0, 0, 0, "R8");
      idle(8);
      cur_cl = 0;
      // R9: write right after burst stop
      step(K_BST, 0, 0, 0, "R9");
      step(K_WR, 0, 0, 0, "R9");
      idle(8);
      // R10: idle-bank rule and read-to-write rule together
      step(K_ACT, 3, 0, 0, "R10");
      idle(8);
      step(K_RD, 3, 1, 0, "R10");
      step(K_WR, 3, 0, 0, "R10");
      idle(8);
      // R11: long gap after a write must not wrap
      step(K_ACT, 1, 0, 0, "R11");
      idle(8);
      step(K_WR, 1, 0, 0, "R11");
      idle(40);
      step(K_PRE, 1, 0, 0, "R11");
      idle(8);
      // constrained random traffic
      for (int n = 0; n < 3000; n++) begin
         int r, c;
         bit cs;
         if (n % 500 == 0) begin
            cur_bl = $urandom % 4;
            cur_cl = $urandom % 2;
         end
         r  = $urandom % 100;
         cs = 1'b0;
         if (r < 20)      c = K_ACT;
         else if (r < 40) c = K_RD;
         else if (r < 60) c = K_WR;
         else if (r < 72) c = K_PRE;
         else if (r < 76) c = K_MRS;
         else if (r < 82) c = K_BST;
         else if (r < 85) c = K_REF;
         else if (r < 95) c = K_NOP;
         else begin c = $urandom % 8; cs = 1'b1; end
         step(c, $urandom % 4, ($urandom % 10) < 3, cs, "");
      end
      step(K_NOP, 0, 0, 0, "");
      @(negedge clk);
      check(pend_tag, pend_code);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         bad++;
         $display("FAIL R10: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule